// File: doc/BRIEF.md
# ADC Serial Command Front End

This block is the device-side serial front end of a 12-bit successive-approximation converter. The external serial clock clocks it, and an active-low chip select frames each transfer. The host may clock in any number of zeros before it sends a one. That one is the start bit. The four bits after it form a configuration word. The word selects single-ended or pseudo-differential input, and it picks the positive and negative mux channels that go to the analog multiplexer.

After the configuration word, the block raises a sample strobe that covers a fixed window of clock edges. Next it drives a low null bit. It then shifts out the conversion result, most significant bit first. During that phase, a per-bit conversion strobe and a bit index tell an attached SAR core which result bit it must resolve before each falling edge. Each resolved bit is kept. If the host keeps clocking, the result is replayed least significant bit first, and after that the output carries zeros until chip select rises. The data output changes only on falling clock edges. A separate enable output drives the pin's tristate buffer.

Clock edges below are counted from the start bit. "Clock k" is the k-th serial clock after the rising edge that carried the start bit.

Top module: `adc_serial_front`

## Requirements
- R1: After reset with chip select already low, no start bit is accepted until chip select has been high across a rising clock edge and then gone low again.
- R2: Zeros on din at rising edges before the first one are ignored. The first rising edge with chip select low and din high is the start bit.
- R3: The rising edges of clocks 1, 2, 3 and 4 capture single/differential, then D2, D1, D0. cfg_valid_o is high from the rising edge of clock 4 to the rising edge of clock 5.
- R4: single_o equals the single/differential bit, and mux_pos_o = {D2,D1,D0}. In single-ended mode mux_neg_o is 0. In differential mode mux_neg_o is the other channel of the pair, {D2,D1,~D0}.
- R5: sample_o rises at the rising edge of clock 4 and falls at the falling edge of clock 5. Din is ignored from clock 5 onward, so the configuration outputs do not change.
- R6: At the falling edge of clock 6, dout_oe_o rises and dout_o is 0 (the null bit).
- R7: During clocks 7 to 18, conv_strobe_o is high and conv_idx_o equals 18 minus the clock number. At the falling edge of each of these clocks, dout_o takes result_i[conv_idx_o].
- R8: At the falling edges of clocks 19 to 29, dout_o replays the captured bits 1 through 11, in that order. From clock 30 onward it is 0.
- R9: dout_oe_o is 0 while chip select is high and before the null bit.
- R10: Raising chip select in the middle of a frame abandons it. The next frame then runs normally from its own start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| din_i | input | 1 | Serial command data |
| result_i | input | RES_W | Result bits from the SAR core |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Tristate enable for the data pin |
| cfg_valid_o | output | 1 | Configuration word captured |
| single_o | output | 1 | 1 = single-ended, 0 = pseudo-differential |
| mux_pos_o | output | 3 | Positive input channel |
| mux_neg_o | output | 3 | Negative input channel (0 when single-ended) |
| sample_o | output | 1 | Sample window strobe |
| conv_strobe_o | output | 1 | SAR bit-decision strobe |
| conv_idx_o | output | IDX_W | Result bit being decided |

## Verification
The assertions assume the following about the inputs:
- Chip select stays high for a full serial clock period, covering both a rising and a falling edge, between frames.
- din and chip select change away from the rising edge.
- The SAR core presents result_i[conv_idx_o] before each falling edge while conv_strobe_o is high.

The bench meets these assumptions as follows:
- It changes every input shortly after a falling edge.
- It holds chip select high for a whole period before each frame.
- Its SAR model drives the true result only while the conversion strobe is high and the inverted result otherwise, so a design that reads result_i outside its strobe window gives wrong bits.

// File: rtl/adc_sfe_pkg.sv
package adc_sfe_pkg;

  typedef enum logic [2:0] {
    PH_CFG    = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_NULL   = 3'd2,
    PH_MSB    = 3'd3,
    PH_LSB    = 3'd4,
    PH_ZERO   = 3'd5
  } phase_e;

  // Last clock of the MSB-first phase, counted from the start bit.
  function automatic int msb_last(int res_w);
    return res_w + 6;
  endfunction

  // Phase of a frame for a given clock count after the start bit.
  function automatic phase_e phase_of(int cnt, int res_w);
    if (cnt <= 3)                   return PH_CFG;
    if (cnt <= 5)                   return PH_SAMPLE;
    if (cnt == 6)                   return PH_NULL;
    if (cnt <= msb_last(res_w))     return PH_MSB;
    if (cnt <= 2 * res_w + 5)       return PH_LSB;
    return PH_ZERO;
  endfunction

  // Negative mux input: ground reference when single-ended, pair partner otherwise.
  function automatic logic [2:0] neg_chan(logic single, logic [2:0] sel);
    return single ? 3'd0 : {sel[2:1], ~sel[0]};
  endfunction

endpackage

// File: rtl/adc_sfe_cmd_rx.sv
module adc_sfe_cmd_rx #(
  parameter int RES_W = 12,
  localparam int CNT_MAX = 2 * RES_W + 6,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic             sclk_i,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             din_i,
  output logic             started_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [3:0]       cfg_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] CFG_BITS = CNT_W'(4);

  logic armed;

  always_ff @(posedge sclk_i or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      started_o <= 1'b0;
      cnt_o     <= '0;
      cfg_o     <= '0;
    end else if (cs_n_i) begin
      armed     <= 1'b1;
      started_o <= 1'b0;
      cnt_o     <= '0;
    end else if (!started_o) begin
      if (armed && din_i) begin
        started_o <= 1'b1;
        cnt_o     <= '0;
      end
    end else begin
      if (cnt_o != CNT_LAST) cnt_o <= cnt_o + 1'b1;
      if (cnt_o < CFG_BITS)  cfg_o <= {cfg_o[2:0], din_i};
    end
  end

  // R1
  arm_gate_chk: assert property (@(posedge sclk_i) disable iff (!rst_n)
    (!armed && !started_o) |=> !started_o);

  // R2
  start_origin_chk: assert property (@(posedge sclk_i) disable iff (!rst_n)
    $rose(started_o) |-> (cnt_o == '0));

endmodule

// File: rtl/adc_sfe_dout_seq.sv
module adc_sfe_dout_seq
  import adc_sfe_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int CNT_MAX = 2 * RES_W + 6,
  localparam int CNT_W = $clog2(CNT_MAX + 1),
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             sclk_i,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             started_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_q,
  output logic             drive_q,
  output logic             sample_done_q
);

  localparam logic [CNT_W-1:0] MSB_END   = CNT_W'(msb_last(RES_W));
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(5);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CNT_MAX);

  logic [RES_W-1:0] hold_q;
  logic [IDX_W-1:0] msb_idx, lsb_idx;
  phase_e           ph;

  assign ph      = phase_of(int'(cnt_i), RES_W);
  assign msb_idx = IDX_W'(MSB_END - cnt_i);
  assign lsb_idx = IDX_W'(cnt_i - MSB_END);

  always_ff @(negedge sclk_i or negedge rst_n) begin
    if (!rst_n) begin
      dout_q        <= 1'b0;
      drive_q       <= 1'b0;
      sample_done_q <= 1'b0;
      hold_q        <= '0;
    end else if (cs_n_i || !started_i) begin
      dout_q        <= 1'b0;
      drive_q       <= 1'b0;
      sample_done_q <= 1'b0;
    end else begin
      case (ph)
        PH_SAMPLE: if (cnt_i == SAMP_LAST) sample_done_q <= 1'b1;
        PH_NULL: begin
          drive_q <= 1'b1;
          dout_q  <= 1'b0;
        end
        PH_MSB: begin
          dout_q          <= result_i[msb_idx];
          hold_q[msb_idx] <= result_i[msb_idx];
        end
        PH_LSB:  dout_q <= hold_q[lsb_idx];
        default: dout_q <= 1'b0;
      endcase
    end
  end

  // R6
  null_low_chk: assert property (@(posedge sclk_i) disable iff (!rst_n)
    $rose(drive_q) |-> !dout_q);

  // R8
  zero_fill_chk: assert property (@(posedge sclk_i) disable iff (!rst_n)
    (drive_q && !cs_n_i && started_i && cnt_i == CNT_LAST) |-> !dout_q);

endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
  import adc_sfe_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int CNT_MAX = 2 * RES_W + 6,
  localparam int CNT_W = $clog2(CNT_MAX + 1),
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             sclk_i,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             din_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             cfg_valid_o,
  output logic             single_o,
  output logic [2:0]       mux_pos_o,
  output logic [2:0]       mux_neg_o,
  output logic             sample_o,
  output logic             conv_strobe_o,
  output logic [IDX_W-1:0] conv_idx_o
);

  localparam logic [CNT_W-1:0] MSB_END   = CNT_W'(msb_last(RES_W));
  localparam logic [CNT_W-1:0] CFG_DONE  = CNT_W'(4);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(5);

  logic             started;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       cfg;
  logic             drive_q, dout_q, sample_done_q;
  phase_e           ph;

  adc_sfe_cmd_rx #(.RES_W(RES_W)) u_rx (
    .sclk_i    (sclk_i),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .din_i     (din_i),
    .started_o (started),
    .cnt_o     (cnt),
    .cfg_o     (cfg)
  );

  adc_sfe_dout_seq #(.RES_W(RES_W)) u_seq (
    .sclk_i        (sclk_i),
    .rst_n         (rst_n),
    .cs_n_i        (cs_n_i),
    .started_i     (started),
    .cnt_i         (cnt),
    .result_i      (result_i),
    .dout_q        (dout_q),
    .drive_q       (drive_q),
    .sample_done_q (sample_done_q)
  );

  assign ph            = phase_of(int'(cnt), RES_W);
  assign cfg_valid_o   = started && (cnt == CFG_DONE);
  assign single_o      = cfg[3];
  assign mux_pos_o     = cfg[2:0];
  assign mux_neg_o     = neg_chan(cfg[3], cfg[2:0]);
  assign sample_o      = started && (ph == PH_SAMPLE) &&
                         !((cnt == SAMP_LAST) && sample_done_q);
  assign conv_strobe_o = started && (ph == PH_MSB);
  assign conv_idx_o    = IDX_W'(MSB_END - cnt);
  assign dout_o        = dout_q;
  assign dout_oe_o     = drive_q && !cs_n_i;

  // R3
  cfg_pulse_chk: assert property (@(posedge sclk_i) disable iff (!rst_n)
    cfg_valid_o |=> !cfg_valid_o);

  // R5
  sample_vs_conv_chk: assert property (@(posedge sclk_i) disable iff (!rst_n)
    !(sample_o && conv_strobe_o));

  // R7
  conv_driving_chk: assert property (@(posedge sclk_i) disable iff (!rst_n)
    (conv_strobe_o && !cs_n_i) |-> dout_oe_o);

endmodule

// File: tb/adc_serial_front_bench.sv
`timescale 1ns/100ps
module adc_serial_front_bench;

  localparam int RES_W = 12;
  localparam int IDX_W = $clog2(RES_W);

  logic             sclk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cs_n = 1'b0;
  logic             din = 1'b0;
  logic [RES_W-1:0] rv = '0;
  logic [RES_W-1:0] result;
  logic             dout, dout_oe, cfg_valid, single, sample, conv_strobe;
  logic [2:0]       mux_pos, mux_neg;
  logic [IDX_W-1:0] conv_idx;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  logic exp_q[$];

  always #10 sclk = ~sclk;

  // SAR model: the true result only while the core is asked for a bit.
  assign result = conv_strobe ? rv : ~rv;

  adc_serial_front #(.RES_W(RES_W)) u_adc_serial_front (
    .sclk_i(sclk), .rst_n(rst_n), .cs_n_i(cs_n), .din_i(din),
    .result_i(result), .dout_o(dout), .dout_oe_o(dout_oe),
    .cfg_valid_o(cfg_valid), .single_o(single), .mux_pos_o(mux_pos),
    .mux_neg_o(mux_neg), .sample_o(sample), .conv_strobe_o(conv_strobe),
    .conv_idx_o(conv_idx)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic exp_bit(logic [RES_W-1:0] v, int k);
    if (k == 6) return 1'b0;
    if (k >= 7 && k <= RES_W + 6) return v[RES_W + 6 - k];
    if (k >= RES_W + 7 && k <= 2 * RES_W + 5) return v[k - RES_W - 6];
    return 1'b0;
  endfunction

  // Monitor: pops one expected bit per driven falling edge.
  always @(negedge sclk) begin
    #0.5;
    if (mon_en && dout_oe === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected drive: actual=1 expected=0");
      end else begin
        logic e;
        e = exp_q.pop_front();
        chk("R8 serial stream bit (R6 null, R7 MSB-first)", dout, e);
      end
    end
  end

  task automatic run_frame(int lead, logic [3:0] cfg, logic [RES_W-1:0] val, int nclk);
    logic [2:0] epos;
    logic [2:0] eneg;
    epos = cfg[2:0];
    eneg = cfg[3] ? 3'd0 : (cfg[2:0] ^ 3'b001);
    for (int k = 6; k <= nclk; k++) exp_q.push_back(exp_bit(val, k));
    @(negedge sclk); #1;
    cs_n = 1'b0; rv = val;
    for (int i = 0; i < lead; i++) begin
      din = 1'b0;
      @(posedge sclk); #1;
      chk("R2 leading zero ignored (cfg_valid)", cfg_valid, 0);
      chk("R2 leading zero ignored (sample)", sample, 0);
      @(negedge sclk); #1;
    end
    din = 1'b1;
    @(posedge sclk);
    @(negedge sclk); #1;
    for (int k = 1; k <= nclk; k++) begin
      din = (k <= 4) ? cfg[4 - k] : k[0];
      @(posedge sclk); #1;
      if (k == 3) chk("R5 sample low before clock 4", sample, 0);
      if (k == 3) chk("R3 cfg_valid low at clock 3", cfg_valid, 0);
      if (k == 4) begin
        chk("R3 cfg_valid at clock 4", cfg_valid, 1);
        chk("R5 sample rises at clock 4", sample, 1);
        chk("R4 single flag", single, cfg[3]);
        chk("R4 positive channel", mux_pos, epos);
        chk("R4 negative channel", mux_neg, eneg);
      end
      if (k == 5) begin
        chk("R3 cfg_valid low at clock 5", cfg_valid, 0);
        chk("R5 sample held into clock 5", sample, 1);
      end
      if (k >= 5) begin
        chk("R5 din ignored, positive channel", mux_pos, epos);
        chk("R5 din ignored, single flag", single, cfg[3]);
      end
      chk("R7 conv strobe window", conv_strobe, (k >= 7 && k <= RES_W + 6));
      if (k >= 7 && k <= RES_W + 6) chk("R7 conv index", conv_idx, RES_W + 6 - k);
      @(negedge sclk); #1;
      if (k == 5) begin
        chk("R5 sample ends at falling edge of clock 5", sample, 0);
        chk("R9 no drive before null bit", dout_oe, 0);
      end
      if (k == 6) chk("R6 drive enabled at null bit", dout_oe, 1);
    end
    cs_n = 1'b1; din = 1'b0;
    #1;
    chk("R9 released when chip select high", dout_oe, 0);
    @(posedge sclk);
    @(negedge sclk); #1;
    chk("R10 expected stream consumed", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #15;
    chk("R9 reset drive", dout_oe, 0);
    chk("R5 reset sample", sample, 0);
    chk("R3 reset cfg_valid", cfg_valid, 0);
    chk("R7 reset strobe", conv_strobe, 0);
    @(negedge sclk); #1;
    rst_n = 1'b1;
    mon_en = 1'b1;
    // R1: chip select low since power-up, start bits must be refused.
    for (int i = 0; i < 8; i++) begin
      din = 1'b1;
      @(posedge sclk); #1;
      chk("R1 no start before chip select cycles (cfg_valid)", cfg_valid, 0);
      chk("R1 no start before chip select cycles (sample)", sample, 0);
      @(negedge sclk); #1;
      chk("R1 no drive before chip select cycles", dout_oe, 0);
    end
    cs_n = 1'b1; din = 1'b0;
    @(posedge sclk);
    @(negedge sclk); #1;
    run_frame(0, 4'b1101, 12'hA5C, 34);
    run_frame(5, 4'b0110, 12'hFFF, 30);
    run_frame(2, 4'b0011, 12'h000, 20);
    // R10: abandon a frame in the MSB-first phase, then run a full one.
    run_frame(1, 4'b1000, 12'h123, 12);
    run_frame(0, 4'b1111, 12'h801, 31);
    run_frame(3, 4'b0000, 12'h5A6, 29);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule